// File: doc/BRIEF.md
# Adaptive Segment Offset Update Controller

This block sits beside a segmented converter correction path and keeps its eight per-segment correction offsets current. Gap trackers outside the block measure the code gap at each of the seven segment boundaries. A free-running period counter runs in the background. Each time the counter wraps, the block takes a snapshot of the measured gaps. From the snapshot it forms a target offset for every segment. It moves each stored offset a fraction 2^-s of the way toward its target. It then writes the rounded results into the correction storage, one segment per clock, and clears the gap trackers on the last write. The conversion path is never stalled. The block only writes into the storage that the path reads.

Control is a two-state machine. **ST_IDLE** counts, and leaves on the *start* transition when the counter wraps with adaptation enabled and every boundary observed on both sides. **ST_WRITE** steps through segments 0 to 7, one per cycle. It takes the *finish* transition back to ST_IDLE after segment 7. If the counter wraps while adaptation is disabled, or while a boundary is still unobserved, the machine stays in ST_IDLE and nothing is written.

Top module: `adc_cal_update_ctrl`

## Requirements
- R1: A write burst starts on the clock after the period counter wraps. With the default 11-bit counter, successive bursts start exactly 2048 cycles apart.
- R2: A burst is eight consecutive cycles with `wr_en` high and `wr_addr` counting 0,1,...,7. Outside a burst, `wr_en` is low.
- R3: The target for segment k, in half-LSB units, is t2_k = G − 2·P_k. G is the sum of all seven gaps and P_k is the sum of gaps 0..k−1. Gap j is `gap_vec[6j+5:6j]` and lies between segments j and j+1.
- R4: Each segment holds a value v with 8 fractional bits. On its write, v becomes v + floor((t2_k·128 − v) / 2^s). s is `lam_shift`, and a value of 0 is used as 1.
- R5: The written value `wr_data` (two's complement, 10 bits) is floor((v + 128) / 256), that is, the new v rounded half up to an integer.
- R6: After reset `wr_en` and `trk_clear` are low. The held values start at the nominal targets for gaps 1,2,1,4,1,2,1, which are +6,+5,+3,+2,−2,−3,−5,−6.
- R7: `trk_clear` is high only in the cycle of the segment-7 write.
- R8: If any `gap_valid` bit is low when the counter wraps, there is no write and no clear, and the held values stay unchanged.
- R9: If `adapt_en` is low when the counter wraps, there is no write and no clear, and the held values stay unchanged.
- R10: The targets come from gaps sampled in the wrap cycle. Changes on `gap_vec` during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adapt_en | input | 1 | Allows updates; low freezes the offsets |
| lam_shift | input | 3 | Adaptation shift s, step size 2^-s (0 acts as 1) |
| gap_vec | input | 42 | Seven measured boundary gaps, 6 bits each, gap 0 in the low bits |
| gap_valid | input | 7 | Per boundary: both sides have been observed |
| wr_en | output | 1 | Correction storage write strobe |
| wr_addr | output | 3 | Segment being written |
| wr_data | output | 10 | Rounded signed offset for that segment |
| trk_clear | output | 1 | Clears the gap trackers, on the last write |

## Verification
The bench keeps its own fixed-point model of the eight held values and compares every written offset against it. The stimulus covers nominal gaps (which must leave the offsets unchanged), uniform, zero, extreme and irregular gap sets, shifts of 0, 1, 2, 3 and 7, and negative values that exercise floor rounding. A design that mis-sums the prefix, shifts the wrong way, or truncates instead of rounding would drift away from the model within one burst. Counter wraps with one boundary unobserved, or with adaptation disabled, must produce no writes. A design that blended anyway would also show up later as wrong values in the next real burst. The gaps are changed in the middle of one burst, so a design that reads live gaps instead of its snapshot gives wrong later offsets. The spacing between bursts is measured to catch an off-by-one period.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_WRITE
    } upd_state_t;

    // Nominal gap at boundary j: lowest set bit of j+1 (1,2,1,4,1,2,1,...)
    function automatic int nom_gap(int j);
        for (int b = 0; b < 30; b++) begin
            if ((((j + 1) >> b) % 2) == 1) return 1 << b;
        end
        return 1;
    endfunction

    // Nominal target of segment k in half-LSB units
    function automatic int nom_target2(int k, int ngap);
        int tot;
        int pre;
        tot = 0;
        pre = 0;
        for (int j = 0; j < ngap; j++) begin
            tot += nom_gap(j);
            if (j < k) pre += nom_gap(j);
        end
        return tot - 2 * pre;
    endfunction

endpackage

// File: rtl/adc_cal_period_ctr.sv
module adc_cal_period_ctr #(
    parameter int PERIOD_W = 11
) (
    input  logic clk,
    input  logic rst_n,
    output logic ovf
);
    logic [PERIOD_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + PERIOD_W'(1);
    end

    // Wrap cycle: the next value is zero
    assign ovf = &cnt_q;
endmodule

// File: rtl/adc_cal_target.sv
module adc_cal_target #(
    parameter int NSEG  = 8,
    parameter int GAP_W = 6,
    parameter int T2_W  = GAP_W + $clog2(NSEG) + 2
) (
    input  logic [(NSEG-1)*GAP_W-1:0] gap_vec,
    output logic signed [T2_W-1:0]    t2 [NSEG]
);
    localparam int NGAP  = NSEG - 1;
    localparam int SUM_W = T2_W - 2;

    logic [SUM_W-1:0] pre [NSEG];

    assign pre[0] = '0;

    genvar k;
    for (k = 0; k < NGAP; k++) begin : g_pre
        assign pre[k+1] = pre[k] + SUM_W'(gap_vec[k*GAP_W +: GAP_W]);
    end

    // total - 2*prefix, in half-LSB units
    for (k = 0; k < NSEG; k++) begin : g_t2
        assign t2[k] = $signed({2'b00, pre[NGAP]}) - $signed({1'b0, pre[k], 1'b0});
    end
endmodule

// File: rtl/adc_cal_blend.sv
module adc_cal_blend #(
    parameter int ACC_W   = 18,
    parameter int FRAC_W  = 8,
    parameter int SHIFT_W = 3,
    parameter int OFS_W   = 10,
    parameter int T2_W    = 11
) (
    input  logic signed [ACC_W-1:0] acc_old,
    input  logic signed [T2_W-1:0]  t2,
    input  logic [SHIFT_W-1:0]      shift,
    output logic signed [ACC_W-1:0] acc_new,
    output logic signed [OFS_W-1:0] ofs
);
    logic [SHIFT_W-1:0]     s_eff;
    logic signed [ACC_W:0]  tfx;
    logic signed [ACC_W:0]  diff;
    logic signed [ACC_W:0]  step;
    logic signed [ACC_W:0]  sum;
    logic signed [ACC_W-1:0] rnd;

    // lambda must stay below one: shift 0 behaves as 1
    assign s_eff = (shift == '0) ? SHIFT_W'(1) : shift;

    always_comb begin
        tfx     = (ACC_W+1)'(t2) <<< (FRAC_W - 1);
        diff    = tfx - (ACC_W+1)'(acc_old);
        step    = diff >>> s_eff;
        sum     = (ACC_W+1)'(acc_old) + step;
        acc_new = ACC_W'(sum);
        rnd     = acc_new + ACC_W'(1 << (FRAC_W - 1));
        ofs     = OFS_W'(rnd >>> FRAC_W);
    end
endmodule

// File: rtl/adc_cal_update_ctrl.sv
module adc_cal_update_ctrl
    import adc_cal_pkg::*;
#(
    parameter int NSEG     = 8,
    parameter int GAP_W    = 6,
    parameter int PERIOD_W = 11,
    parameter int FRAC_W   = 8,
    parameter int SHIFT_W  = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  adapt_en,
    input  logic [SHIFT_W-1:0]                    lam_shift,
    input  logic [(NSEG-1)*GAP_W-1:0]             gap_vec,
    input  logic [NSEG-2:0]                       gap_valid,
    output logic                                  wr_en,
    output logic [$clog2(NSEG)-1:0]               wr_addr,
    output logic signed [GAP_W+$clog2(NSEG):0]    wr_data,
    output logic                                  trk_clear
);
    localparam int NGAP   = NSEG - 1;
    localparam int SEG_AW = $clog2(NSEG);
    localparam int SUM_W  = GAP_W + SEG_AW;
    localparam int T2_W   = SUM_W + 2;
    localparam int OFS_W  = SUM_W + 1;
    localparam int ACC_W  = OFS_W + FRAC_W;

    upd_state_t          state_q, state_d;
    logic [SEG_AW-1:0]   idx_q, idx_d;
    logic                ovf;
    logic                upd_start;
    logic [NGAP*GAP_W-1:0] snap_q;
    logic signed [ACC_W-1:0] acc_q [NSEG];
    logic signed [T2_W-1:0]  t2 [NSEG];
    logic signed [ACC_W-1:0] acc_new;
    logic signed [OFS_W-1:0] ofs_new;

    adc_cal_period_ctr #(.PERIOD_W(PERIOD_W)) u_period (
        .clk   (clk),
        .rst_n (rst_n),
        .ovf   (ovf)
    );

    adc_cal_target #(.NSEG(NSEG), .GAP_W(GAP_W), .T2_W(T2_W)) u_target (
        .gap_vec (snap_q),
        .t2      (t2)
    );

    adc_cal_blend #(
        .ACC_W(ACC_W), .FRAC_W(FRAC_W), .SHIFT_W(SHIFT_W),
        .OFS_W(OFS_W), .T2_W(T2_W)
    ) u_blend (
        .acc_old (acc_q[idx_q]),
        .t2      (t2[idx_q]),
        .shift   (lam_shift),
        .acc_new (acc_new),
        .ofs     (ofs_new)
    );

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        idx_d     = idx_q;
        upd_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ovf && adapt_en && (&gap_valid)) begin
                    state_d   = ST_WRITE;
                    idx_d     = '0;
                    upd_start = 1'b1;
                end
            end
            ST_WRITE: begin
                if (idx_q == SEG_AW'(NSEG - 1)) begin
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + SEG_AW'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Gap snapshot and held fixed-point offsets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            for (int k = 0; k < NSEG; k++) begin
                acc_q[k] <= ACC_W'(nom_target2(k, NGAP) * (2 ** (FRAC_W - 1)));
            end
        end else begin
            if (upd_start) snap_q <= gap_vec;
            if (state_q == ST_WRITE) acc_q[idx_q] <= acc_new;
        end
    end

    // Outputs
    always_comb begin
        wr_en     = (state_q == ST_WRITE);
        wr_addr   = idx_q;
        wr_data   = ofs_new;
        trk_clear = (state_q == ST_WRITE) && (idx_q == SEG_AW'(NSEG - 1));
    end
endmodule

// File: rtl/adc_cal_update_ctrl_chk.sv
module adc_cal_update_ctrl_chk #(
    parameter int NSEG  = 8,
    parameter int GAP_W = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        adapt_en,
    input logic [NSEG-2:0]             gap_valid,
    input logic                        ovf,
    input logic                        wr_en,
    input logic [$clog2(NSEG)-1:0]     wr_addr,
    input logic                        trk_clear,
    input logic [(NSEG-1)*GAP_W-1:0]   snap
);
    localparam int SEG_AW = $clog2(NSEG);

    assert_burst_trigger_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(ovf));

    assert_burst_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> (wr_addr == '0));

    assert_burst_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != SEG_AW'(NSEG - 1)) |=>
            (wr_en && wr_addr == SEG_AW'($past(wr_addr) + 1'b1)));

    assert_burst_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SEG_AW'(NSEG - 1)) |=> !wr_en);

    assert_clear_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trk_clear |-> (wr_en && wr_addr == SEG_AW'(NSEG - 1)));

    assert_skip_unseen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !wr_en && !(&gap_valid)) |=> (!wr_en && !trk_clear));

    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !wr_en && !adapt_en) |=> (!wr_en && !trk_clear));

    assert_snapshot_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> $stable(snap));
endmodule

bind adc_cal_update_ctrl adc_cal_update_ctrl_chk #(.NSEG(NSEG), .GAP_W(GAP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .adapt_en  (adapt_en),
    .gap_valid (gap_valid),
    .ovf       (ovf),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .trk_clear (trk_clear),
    .snap      (snap_q)
);

// File: tb/adc_cal_update_ctrl_tb.sv
module adc_cal_update_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adapt_en = 1'b1;
    logic [2:0]  lam_shift = 3'd1;
    logic [41:0] gap_vec = '0;
    logic [6:0]  gap_valid = '1;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic signed [9:0] wr_data;
    logic        trk_clear;

    int     n_checks = 0;
    int     n_errors = 0;
    longint cyc = 0;
    bit     done = 0;
    longint v [8];
    longint start_cyc [2];

    // {shift, g6..g0}
    localparam logic [44:0] VEC [6] = '{
        {3'd1, 6'd1,  6'd2,  6'd1,  6'd4,  6'd1,  6'd2,  6'd1},
        {3'd1, 6'd3,  6'd3,  6'd3,  6'd3,  6'd3,  6'd3,  6'd3},
        {3'd2, 6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  6'd0},
        {3'd3, 6'd63, 6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  6'd63},
        {3'd0, 6'd4,  6'd3,  6'd7,  6'd2,  6'd9,  6'd1,  6'd5},
        {3'd7, 6'd1,  6'd60, 6'd50, 6'd40, 6'd30, 6'd20, 6'd10}
    };

    adc_cal_update_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .adapt_en(adapt_en), .lam_shift(lam_shift),
        .gap_vec(gap_vec), .gap_valid(gap_valid), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .trk_clear(trk_clear)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One full update burst, compared against the bench model
    task automatic run_update(bit alter, output longint st);
        int     w = 0;
        longint tot = 0, pre = 0, t2, d, e;
        int     s;
        logic [41:0] cur;
        while (!wr_en && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk(wr_en, "R1 burst start", wr_en, 1);
        st  = cyc;
        cur = gap_vec;
        s   = (lam_shift == 0) ? 1 : int'(lam_shift);
        for (int j = 0; j < 7; j++) tot += cur[j*6 +: 6];
        for (int k = 0; k < 8; k++) begin
            t2   = tot - 2 * pre;
            d    = t2 * 128 - v[k];
            v[k] = v[k] + (d >>> s);
            e    = (v[k] + 128) >>> 8;
            chk(wr_en && wr_addr == 3'(k), "R2 write order", wr_addr, k);
            chk(longint'(wr_data) == e, alter ? "R10 R3 R4 R5 value" : "R3 R4 R5 value",
                longint'(wr_data), e);
            chk(trk_clear == (k == 7), "R7 tracker clear", trk_clear, (k == 7));
            if (k < 7) pre += cur[k*6 +: 6];
            if (alter && k == 2) gap_vec = ~cur;
            @(negedge clk);
        end
        chk(!wr_en && !trk_clear, "R2 burst end", wr_en, 0);
    endtask

    task automatic watch_quiet(int n, string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wr_en || trk_clear) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    initial begin
        longint st;
        int nom [7] = '{1, 2, 1, 4, 1, 2, 1};
        longint p = 0;
        for (int k = 0; k < 8; k++) begin
            v[k] = (12 - 2 * p) * 128;
            if (k < 7) p += nom[k];
        end
        repeat (4) @(negedge clk);
        chk(!wr_en && !trk_clear, "R6 outputs in reset", wr_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_en, "R6 write idle after reset", wr_en, 0);
        chk(!trk_clear, "R6 clear idle after reset", trk_clear, 0);

        // Table walk (first entry: nominal gaps leave R6 offsets unchanged)
        for (int i = 0; i < 6; i++) begin
            gap_vec   = VEC[i][41:0];
            lam_shift = VEC[i][44:42];
            run_update(1'b0, st);
            if (i < 2) start_cyc[i] = st;
        end
        chk(start_cyc[1] - start_cyc[0] == 2048, "R1 update period",
            start_cyc[1] - start_cyc[0], 2048);

        // Unobserved boundary: no update, values untouched
        gap_vec   = {6'd9, 6'd9, 6'd9, 6'd9, 6'd9, 6'd9, 6'd9};
        lam_shift = 3'd1;
        gap_valid = 7'b1110111;
        watch_quiet(2100, "R8 skipped update");
        gap_valid = '1;
        run_update(1'b0, st);

        // Frozen adaptation
        gap_vec  = {6'd2, 6'd5, 6'd8, 6'd11, 6'd14, 6'd17, 6'd20};
        adapt_en = 1'b0;
        watch_quiet(2100, "R9 frozen update");
        adapt_en = 1'b1;
        run_update(1'b0, st);

        // Gap change during a burst
        gap_vec   = {6'd6, 6'd1, 6'd12, 6'd3, 6'd25, 6'd0, 6'd7};
        lam_shift = 3'd2;
        run_update(1'b1, st);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule